// File: doc/BRIEF.md
# DRAM Bank Page-Policy Command Sequencer

This block takes memory transactions (bank, row, column, a write flag and an auto-precharge request) and turns each one into DRAM commands on a single command output: Activate, Precharge, and a CAS read or write, with or without auto-precharge. It keeps, for every bank, whether a row is open, which row that is, and a countdown timer. A bank stays open after an ordinary CAS, so later accesses to the same row need only the CAS. A bank closes only for a pending refresh, for a page miss, or through an auto-precharge CAS.

Transactions enter a two-entry in-order queue. The entry at the head is serviced in order. The entry behind it is inspected, and if it targets another bank that is open on the wrong row, that bank is precharged early while the head is waiting on a timer. The per-transaction auto-precharge request can be overridden by a force mode. In force mode, column bit 3 alone decides whether auto-precharge is used. While refresh is requested, no row is opened, every open bank is precharged, and a ready flag reports when all banks are closed and their timers have expired.

Top module: `dram_page_sequencer`

## Requirements
- R1: After reset `cmdValid` is 0 and `cmdType` is NOP (0). At most one command is issued per clock. Command codes are ACT=1, PRE=2, RD=4, WR=5, RDA=6, WRA=7, and `cmdType` is 0 whenever `cmdValid` is 0.
- R2: A transaction to a closed, idle bank produces an ACT carrying its row, followed by its CAS exactly T_RCD cycles after the ACT.
- R3: After a plain RD or WR the bank stays open. A later transaction to the same bank and row produces only a CAS, with no ACT or PRE, and every CAS targets the row that is open in its bank.
- R4: A transaction to an open bank holding a different row produces a PRE, then an ACT exactly T_RP cycles later, then the CAS exactly T_RCD cycles after that.
- R5: With force mode off, a transaction whose `txnAutoPre` is 1 issues RDA or WRA in place of RD or WR, and that CAS closes the bank.
- R6: After an RDA or WRA, the next transaction to a different row of that bank issues an ACT with no PRE. That ACT comes exactly T_APR cycles after the auto-precharge CAS.
- R7: With `forceAutoPre` = 1, a transaction uses auto-precharge exactly when bit 3 of its column is 1, and `txnAutoPre` has no effect.
- R8: When the head is stalled on a timer and the queued second transaction targets a different bank that is open on another row, that bank's PRE is issued before the head's CAS.
- R9: While `refreshDue` is 1, no ACT is issued and every open bank receives a PRE. `refreshReady` is 1 exactly when `refreshDue` is 1 and all banks are closed with expired timers.
- R10: `txnReady` is 1 while fewer than two transactions are queued, and queued transactions complete in arrival order.
- R11: The write flag selects WR/WRA when 1 and RD/RDA when 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txnValid | input | 1 | Transaction offered |
| txnReady | output | 1 | Queue has room; transaction taken when valid and ready |
| txnBank | input | BANK_W | Target bank |
| txnRow | input | ROW_W | Target row |
| txnCol | input | COL_W | Target column |
| txnWrite | input | 1 | 1 = write, 0 = read |
| txnAutoPre | input | 1 | Request auto-precharge on the CAS |
| forceAutoPre | input | 1 | Column bit 3 decides auto-precharge; txnAutoPre ignored |
| refreshDue | input | 1 | Refresh pending: close all banks |
| refreshReady | output | 1 | All banks closed and idle while refresh pending |
| cmdValid | output | 1 | Command issued this cycle |
| cmdType | output | 3 | Command code (see R1) |
| cmdBank | output | BANK_W | Command bank |
| cmdRow | output | ROW_W | Row for ACT and CAS |
| cmdCol | output | COL_W | Column for CAS |

## Verification
The bench builds the block with four banks and T_RCD=3, T_RP=5, T_APR=7. Because the three delays differ, swapping any two of them changes a measured gap between commands, and the exact cycle distances in R2, R4 and R6 expose that. Two-entry sequences put the look-ahead precharge and the queue-full condition within reach. A refresh window with three open banks and stalled transactions exercises the refresh closing and the ban on opening rows.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd4,
    CMD_WR  = 3'd5,
    CMD_RDA = 3'd6,
    CMD_WRA = 3'd7
  } cmdKind_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic     issue;       // a command goes out this cycle
    cmdKind_e kind;        // which command
    logic     fromSecond;  // address taken from the second queue entry
    logic     pop;         // head transaction finished (its CAS issued)
  } ctrlStrobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                            headValid,
  input  logic [BANK_W-1:0]               headBank,
  input  logic [ROW_W-1:0]                headRow,
  input  logic [COL_W-1:0]                headCol,
  input  logic                            headWrite,
  input  logic                            headAp,
  input  logic                            nextValid,
  input  logic [BANK_W-1:0]               nextBank,
  input  logic [ROW_W-1:0]                nextRow,
  input  logic                            forceAutoPre,
  input  logic                            refreshDue,
  input  logic [NUM_BANKS-1:0]            bankOpen,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] openRow,
  input  logic [NUM_BANKS-1:0]            bankIdle,
  output ctrlStrobe_t                     strobe,
  output logic [BANK_W-1:0]               selBank
);
  logic apWanted;
  logic found;

  assign apWanted = forceAutoPre ? headCol[3] : headAp;

  always_comb begin
    strobe     = '0;
    strobe.kind = CMD_NOP;
    selBank    = headBank;
    found      = 1'b0;
    if (refreshDue) begin
      // close every open bank, lowest index first; never open a row
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (!found && bankOpen[b] && bankIdle[b]) begin
          found        = 1'b1;
          strobe.issue = 1'b1;
          strobe.kind  = CMD_PRE;
          selBank      = BANK_W'(b);
        end
      end
    end else begin
      if (headValid && bankIdle[headBank]) begin
        strobe.issue = 1'b1;
        if (bankOpen[headBank] && openRow[headBank] == headRow) begin
          strobe.pop = 1'b1;
          if (headWrite) strobe.kind = apWanted ? CMD_WRA : CMD_WR;
          else           strobe.kind = apWanted ? CMD_RDA : CMD_RD;
        end else if (bankOpen[headBank]) begin
          strobe.kind = CMD_PRE;
        end else begin
          strobe.kind = CMD_ACT;
        end
      end
      // look-ahead: precharge a known page miss behind a stalled head
      if (!strobe.issue && nextValid && nextBank != headBank &&
          bankOpen[nextBank] && bankIdle[nextBank] &&
          openRow[nextBank] != nextRow) begin
        strobe.issue      = 1'b1;
        strobe.kind       = CMD_PRE;
        strobe.fromSecond = 1'b1;
        selBank           = nextBank;
      end
    end
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int T_RCD     = 4,
  parameter int T_RP      = 4,
  parameter int T_APR     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ENT_W    = BANK_W + ROW_W + COL_W + 2,
  localparam int T_MAX    = (T_RCD > T_RP) ? ((T_RCD > T_APR) ? T_RCD : T_APR)
                                           : ((T_RP > T_APR) ? T_RP : T_APR),
  localparam int TMR_W    = $clog2(T_MAX + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            txnValid,
  output logic                            txnReady,
  input  logic [BANK_W-1:0]               txnBank,
  input  logic [ROW_W-1:0]                txnRow,
  input  logic [COL_W-1:0]                txnCol,
  input  logic                            txnWrite,
  input  logic                            txnAutoPre,
  input  logic                            refreshDue,
  input  ctrlStrobe_t                     strobe,
  input  logic [BANK_W-1:0]               selBank,
  output logic                            headValid,
  output logic [BANK_W-1:0]               headBank,
  output logic [ROW_W-1:0]                headRow,
  output logic [COL_W-1:0]                headCol,
  output logic                            headWrite,
  output logic                            headAp,
  output logic                            nextValid,
  output logic [BANK_W-1:0]               nextBank,
  output logic [ROW_W-1:0]                nextRow,
  output logic [NUM_BANKS-1:0]            bankOpen,
  output logic [NUM_BANKS-1:0][ROW_W-1:0] openRow,
  output logic [NUM_BANKS-1:0]            bankIdle,
  output logic                            refreshReady,
  output logic                            cmdValid,
  output logic [2:0]                      cmdType,
  output logic [BANK_W-1:0]               cmdBank,
  output logic [ROW_W-1:0]                cmdRow,
  output logic [COL_W-1:0]                cmdCol
);
  // ---------------- two-entry in-order queue ----------------
  logic [ENT_W-1:0] qMem [2];
  logic [1:0]       qCount, afterPop;
  logic             push;
  logic [COL_W-1:0] nextCol;
  logic             nextWrite, nextAp;

  assign txnReady  = (qCount != 2'd2);
  assign push      = txnValid && txnReady;
  assign afterPop  = qCount - {1'b0, strobe.pop};
  assign headValid = (qCount != 2'd0);
  assign nextValid = (qCount == 2'd2);
  assign {headBank, headRow, headCol, headWrite, headAp} = qMem[0];
  assign {nextBank, nextRow, nextCol, nextWrite, nextAp} = qMem[1];

  always_ff @(posedge clk) begin
    if (!rstN) qCount <= 2'd0;
    else       qCount <= afterPop + {1'b0, push};
  end

  always_ff @(posedge clk) begin
    if (strobe.pop) qMem[0] <= qMem[1];
    if (push)       qMem[afterPop[0]] <= {txnBank, txnRow, txnCol, txnWrite, txnAutoPre};
  end

  // ---------------- per-bank open state and timers ----------------
  logic [ROW_W-1:0] selRow;
  logic [COL_W-1:0] selCol;
  assign selRow = strobe.fromSecond ? nextRow : headRow;
  assign selCol = strobe.fromSecond ? nextCol : headCol;

  logic             openQ [NUM_BANKS];
  logic [ROW_W-1:0] rowQ  [NUM_BANKS];
  logic [TMR_W-1:0] tmrQ  [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ[b] <= 1'b0;
        rowQ[b]  <= '0;
        tmrQ[b]  <= '0;
      end else begin
        if (tmrQ[b] != '0) tmrQ[b] <= tmrQ[b] - 1'b1;
        if (strobe.issue && selBank == BANK_W'(b)) begin
          case (strobe.kind)
            CMD_ACT: begin
              openQ[b] <= 1'b1;
              rowQ[b]  <= selRow;
              tmrQ[b]  <= TMR_W'(T_RCD - 1);
            end
            CMD_PRE: begin
              openQ[b] <= 1'b0;
              tmrQ[b]  <= TMR_W'(T_RP - 1);
            end
            CMD_RDA, CMD_WRA: begin
              openQ[b] <= 1'b0;
              tmrQ[b]  <= TMR_W'(T_APR - 1);
            end
            default: ;
          endcase
        end
      end
    end
    assign bankOpen[b] = openQ[b];
    assign openRow[b]  = rowQ[b];
    assign bankIdle[b] = (tmrQ[b] == '0);
  end

  assign refreshReady = refreshDue && (bankOpen == '0) && (&bankIdle);

  // ---------------- registered command output ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdType  <= CMD_NOP;
      cmdBank  <= '0;
      cmdRow   <= '0;
      cmdCol   <= '0;
    end else begin
      cmdValid <= strobe.issue;
      cmdType  <= strobe.issue ? strobe.kind : CMD_NOP;
      cmdBank  <= selBank;
      cmdRow   <= selRow;
      cmdCol   <= selCol;
    end
  end
endmodule

// File: rtl/dram_page_sequencer.sv
module dram_page_sequencer
  import seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int T_RCD     = 4,
  parameter int T_RP      = 4,
  parameter int T_APR     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnValid,
  output logic              txnReady,
  input  logic [BANK_W-1:0] txnBank,
  input  logic [ROW_W-1:0]  txnRow,
  input  logic [COL_W-1:0]  txnCol,
  input  logic              txnWrite,
  input  logic              txnAutoPre,
  input  logic              forceAutoPre,
  input  logic              refreshDue,
  output logic              refreshReady,
  output logic              cmdValid,
  output logic [2:0]        cmdType,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol
);
  ctrlStrobe_t                     strobe;
  logic [BANK_W-1:0]               selBank, headBank, nextBank;
  logic [ROW_W-1:0]                headRow, nextRow;
  logic [COL_W-1:0]                headCol;
  logic                            headValid, headWrite, headAp, nextValid;
  logic [NUM_BANKS-1:0]            bankOpen, bankIdle;
  logic [NUM_BANKS-1:0][ROW_W-1:0] openRow;

  seq_ctrl #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W)) u_ctrl (
    .headValid(headValid), .headBank(headBank), .headRow(headRow),
    .headCol(headCol), .headWrite(headWrite), .headAp(headAp),
    .nextValid(nextValid), .nextBank(nextBank), .nextRow(nextRow),
    .forceAutoPre(forceAutoPre), .refreshDue(refreshDue),
    .bankOpen(bankOpen), .openRow(openRow), .bankIdle(bankIdle),
    .strobe(strobe), .selBank(selBank)
  );

  seq_datapath #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W),
                 .T_RCD(T_RCD), .T_RP(T_RP), .T_APR(T_APR)) u_dp (
    .clk(clk), .rstN(rstN), .txnValid(txnValid), .txnReady(txnReady),
    .txnBank(txnBank), .txnRow(txnRow), .txnCol(txnCol),
    .txnWrite(txnWrite), .txnAutoPre(txnAutoPre), .refreshDue(refreshDue),
    .strobe(strobe), .selBank(selBank),
    .headValid(headValid), .headBank(headBank), .headRow(headRow),
    .headCol(headCol), .headWrite(headWrite), .headAp(headAp),
    .nextValid(nextValid), .nextBank(nextBank), .nextRow(nextRow),
    .bankOpen(bankOpen), .openRow(openRow), .bankIdle(bankIdle),
    .refreshReady(refreshReady), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol)
  );
endmodule

// File: rtl/dram_page_sequencer_chk.sv
module dram_page_sequencer_chk
  import seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int T_RCD     = 4,
  parameter int T_RP      = 4,
  parameter int T_APR     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              refreshDue,
  input logic              refreshReady,
  input logic              cmdValid,
  input logic [2:0]        cmdType,
  input logic [BANK_W-1:0] cmdBank,
  input logic [ROW_W-1:0]  cmdRow
);
  // independent model of the command stream
  logic [15:0]      sinceAct [NUM_BANKS];
  logic [15:0]      sincePre [NUM_BANKS];
  logic [15:0]      sinceAp  [NUM_BANKS];
  logic             trkOpen  [NUM_BANKS];
  logic [ROW_W-1:0] trkRow   [NUM_BANKS];
  logic [NUM_BANKS-1:0] effOpen;
  logic isAct, isPre, isAp, isCas;

  assign isAct = cmdValid && cmdType == CMD_ACT;
  assign isPre = cmdValid && cmdType == CMD_PRE;
  assign isAp  = cmdValid && (cmdType == CMD_RDA || cmdType == CMD_WRA);
  assign isCas = cmdValid && cmdType[2];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_trk
    logic hit;
    assign hit = (cmdBank == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sinceAct[b] <= 16'hFFFF;
        sincePre[b] <= 16'hFFFF;
        sinceAp[b]  <= 16'hFFFF;
        trkOpen[b]  <= 1'b0;
        trkRow[b]   <= '0;
      end else begin
        sinceAct[b] <= (isAct && hit) ? 16'd1 : (sinceAct[b] == 16'hFFFF ? sinceAct[b] : sinceAct[b] + 16'd1);
        sincePre[b] <= (isPre && hit) ? 16'd1 : (sincePre[b] == 16'hFFFF ? sincePre[b] : sincePre[b] + 16'd1);
        sinceAp[b]  <= (isAp  && hit) ? 16'd1 : (sinceAp[b]  == 16'hFFFF ? sinceAp[b]  : sinceAp[b]  + 16'd1);
        if (isAct && hit) begin
          trkOpen[b] <= 1'b1;
          trkRow[b]  <= cmdRow;
        end else if ((isPre || isAp) && hit) begin
          trkOpen[b] <= 1'b0;
        end
      end
    end
    assign effOpen[b] = (isAct && hit) ? 1'b1 : ((isPre || isAp) && hit) ? 1'b0 : trkOpen[b];
  end

  AST_IDLE_IS_NOP: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> cmdType == CMD_NOP); // R1
  AST_CAS_AFTER_RCD: assert property (@(posedge clk) disable iff (!rstN)
    isCas |-> sinceAct[cmdBank] >= 16'(T_RCD)); // R2
  AST_CAS_OPEN_ROW: assert property (@(posedge clk) disable iff (!rstN)
    isCas |-> trkOpen[cmdBank] && trkRow[cmdBank] == cmdRow); // R3
  AST_ACT_AFTER_RP: assert property (@(posedge clk) disable iff (!rstN)
    isAct |-> !trkOpen[cmdBank] && sincePre[cmdBank] >= 16'(T_RP)); // R4
  AST_ACT_AFTER_APR: assert property (@(posedge clk) disable iff (!rstN)
    isAct |-> sinceAp[cmdBank] >= 16'(T_APR)); // R6
  AST_PRE_ON_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> trkOpen[cmdBank]); // R8
  AST_NO_ACT_IN_REFRESH: assert property (@(posedge clk) disable iff (!rstN)
    isAct |-> !$past(refreshDue)); // R9
  AST_READY_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    refreshReady |-> refreshDue && effOpen == '0); // R9
endmodule

bind dram_page_sequencer dram_page_sequencer_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W),
  .T_RCD(T_RCD), .T_RP(T_RP), .T_APR(T_APR)
) u_chk (.*);

// File: tb/dram_page_sequencer_tb.sv
module dram_page_sequencer_tb;
  localparam int NB = 4, RW = 8, CW = 6;
  localparam int TRCD = 3, TRP = 5, TAPR = 7;

  logic clk = 1'b0, rstN = 1'b0;
  logic txnValid = 0, txnWrite = 0, txnAutoPre = 0, forceAutoPre = 0, refreshDue = 0;
  logic [1:0] txnBank = '0;
  logic [RW-1:0] txnRow = '0;
  logic [CW-1:0] txnCol = '0;
  logic txnReady, refreshReady, cmdValid;
  logic [2:0] cmdType;
  logic [1:0] cmdBank;
  logic [RW-1:0] cmdRow;
  logic [CW-1:0] cmdCol;

  always #5 clk = ~clk;

  dram_page_sequencer #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW),
                        .T_RCD(TRCD), .T_RP(TRP), .T_APR(TAPR)) u_dut (
    .clk(clk), .rstN(rstN), .txnValid(txnValid), .txnReady(txnReady),
    .txnBank(txnBank), .txnRow(txnRow), .txnCol(txnCol), .txnWrite(txnWrite),
    .txnAutoPre(txnAutoPre), .forceAutoPre(forceAutoPre), .refreshDue(refreshDue),
    .refreshReady(refreshReady), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol));

  int vectors = 0, miscompares = 0, cyc = 0, logN = 0;
  int logKind [64], logBank [64], logRow [64], logCol [64], logCyc [64];
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rstN && cmdValid && logN < 64) begin
    logKind[logN] = cmdType; logBank[logN] = cmdBank; logRow[logN] = cmdRow;
    logCol[logN] = cmdCol; logCyc[logN] = cyc; logN++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic push(input int b, input int r, input int c, input bit wr, input bit ap);
    @(negedge clk);
    txnValid = 1; txnBank = 2'(b); txnRow = RW'(r); txnCol = CW'(c);
    txnWrite = wr; txnAutoPre = ap;
    while (!txnReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic endPush();
    @(negedge clk); txnValid = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countKind(input int k, output int n);
    n = 0;
    for (int i = 0; i < logN; i++) if (logKind[i] == k) n++;
  endtask

  task automatic test_reset();
    chk("R1 cmdValid after reset", cmdValid, 0);
    chk("R1 cmdType after reset", cmdType, 0);
    chk("R10 txnReady when empty", txnReady, 1);
    chk("R9 refreshReady without refresh", refreshReady, 0);
  endtask

  task automatic test_closed_and_hit();
    logN = 0;
    push(0, 5, 0, 0, 0); endPush(); settle(15);
    chk("R2 first cmd ACT", logKind[0], 1);
    chk("R2 ACT row", logRow[0], 5);
    chk("R11 read gives RD", logKind[1], 4);
    chk("R2 CAS gap tRCD", logCyc[1] - logCyc[0], TRCD);
    push(0, 5, 1, 1, 0); endPush(); settle(15);
    chk("R3 hit issues single cmd", logN, 3);
    chk("R11 write gives WR", logKind[2], 5);
    chk("R3 hit column", logCol[2], 1);
  endtask

  task automatic test_miss();
    logN = 0;
    push(0, 9, 2, 0, 0); endPush(); settle(25);
    chk("R4 miss cmd count", logN, 3);
    chk("R4 first PRE", logKind[0], 2);
    chk("R4 then ACT", logKind[1], 1);
    chk("R4 ACT new row", logRow[1], 9);
    chk("R4 PRE->ACT gap tRP", logCyc[1] - logCyc[0], TRP);
    chk("R4 ACT->CAS gap tRCD", logCyc[2] - logCyc[1], TRCD);
    chk("R4 CAS is RD", logKind[2], 4);
  endtask

  task automatic test_autopre();
    logN = 0;
    push(0, 9, 3, 1, 1); push(0, 2, 0, 0, 0); endPush(); settle(30);
    chk("R5 WRA issued", logKind[0], 7);
    chk("R6 no PRE after AP", logKind[1], 1);
    chk("R6 ACT gap tAPR", logCyc[1] - logCyc[0], TAPR);
    chk("R6 cmd count", logN, 3);
    chk("R5 plain RD follows", logKind[2], 4);
  endtask

  task automatic test_force();
    int n;
    forceAutoPre = 1;
    logN = 0;
    push(0, 2, 8, 0, 0); push(0, 2, 4, 0, 1); endPush(); settle(30);
    chk("R7 bit3 forces RDA", logKind[0], 6);
    chk("R7 reopen ACT", logKind[1], 1);
    chk("R7 txnAutoPre ignored", logKind[2], 4);
    countKind(2, n);
    chk("R7 no PRE", n, 0);
    forceAutoPre = 0;
  endtask

  task automatic test_lookahead();
    logN = 0;
    push(1, 3, 0, 0, 0); push(0, 7, 0, 0, 0); endPush(); settle(30);
    chk("R8 ACT bank1 first", logKind[0] * 10 + logBank[0], 11);
    chk("R8 early PRE bank0", logKind[1] * 10 + logBank[1], 20);
    chk("R8 PRE one cycle after ACT", logCyc[1] - logCyc[0], 1);
    chk("R8 CAS bank1 after PRE", logKind[2] * 10 + logBank[2], 41);
    chk("R8 ACT bank0 gap tRP", logCyc[3] - logCyc[1], TRP);
    chk("R10 order last CAS bank0", logKind[4] * 10 + logBank[4], 40);
  endtask

  task automatic test_refresh();
    int n;
    push(2, 1, 0, 0, 0); endPush(); settle(15);
    logN = 0;
    @(negedge clk); refreshDue = 1; #1;
    chk("R9 not ready while open", refreshReady, 0);
    push(3, 4, 0, 0, 0); push(3, 4, 1, 0, 0); endPush();
    chk("R10 txnReady low when full", txnReady, 0);
    settle(25);
    countKind(2, n);
    chk("R9 three PREs", n, 3);
    countKind(1, n);
    chk("R9 no ACT during refresh", n, 0);
    chk("R9 refreshReady set", refreshReady, 1);
    refreshDue = 0; #1;
    chk("R9 ready drops", refreshReady, 0);
    logN = 0;
    settle(20);
    chk("R10 ACT bank3 after refresh", logKind[0] * 10 + logBank[0], 13);
    chk("R10 first queued col", logCol[1], 0);
    chk("R10 second queued col", logCol[2], 1);
    chk("R10 queue drained", txnReady, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    test_reset();
    test_closed_and_hit();
    test_miss();
    test_autopre();
    test_force();
    test_lookahead();
    test_refresh();
    summary();
  end
endmodule